// File: doc/BRIEF.md
# Two-Way Secure Mailbox with Isolated Key Path

This block moves messages between a trusted core and an untrusted core. Each direction has its own word FIFO, so the two cores never share a write path. A sender pushes a type word, then a length word, then the payload words, and then strobes a send control. The receiver sees a message-ready interrupt. After it has drained the message it strobes done. Done clears message-ready and raises a receive-complete interrupt to the sender, which stays up until the sender acknowledges it.

Secrets travel outside the shared queue. A third FIFO can be written only by the trusted core. Each write to it also sets a security-valid flag, and that flag is driven out to the untrusted core as a key interrupt. While the flag is set, the untrusted core's read port and pop come from the isolated FIFO rather than from its shared inbound FIFO. The flag clears by itself when the last isolated word is popped, and reads then return to the shared path. If the untrusted core tries to write the isolated FIFO or the security flag, the attempt is ignored and a sticky violation bit is set.

Top module: `sec_mailbox`

## Requirements
- R1: Each direction has its own FIFO: trusted pushes reach only the untrusted read port, and untrusted pushes reach only the trusted read port. Words come out in write order, so type, length and payload arrive as written. The head word is visible on the read data while the FIFO is not empty, and a pop advances to the next word on the following clock edge.
- R2: Each FIFO holds DEPTH words (default 16). A push to a full FIFO is dropped and sets that FIFO's sticky overflow output in the next cycle. The overflow bit stays clear while the FIFO still has room.
- R3: A send strobe from one core sets the other core's message-ready interrupt in the next cycle. The interrupt stays set until the receiver strobes done.
- R4: A done strobe clears the sender's outgoing message-ready interrupt in the next cycle and sets the sender's receive-complete interrupt. That interrupt holds until the sender's acknowledge strobe. If send and done arrive in the same cycle, message-ready stays set.
- R5: A trusted isolated write stores the word in the isolated FIFO and sets security-valid (`u_key_irq`) in the next cycle.
- R6: While security-valid is 1, `u_rdata`, `u_rx_empty` and `u_pop` use the isolated FIFO. While it is 0 they use the shared trusted-to-untrusted FIFO.
- R7: Security-valid returns to 0 in the cycle after the last isolated word is popped, unless a new isolated write arrives in that same cycle. Reads then come from the shared FIFO.
- R8: An untrusted write to the isolated FIFO or to the security flag changes neither the isolated contents nor security-valid, and it sets the sticky `violation` output in the next cycle.
- R9: A pop from an empty FIFO is ignored. Later pushes and pops keep their order.
- R10: After a synchronous active-low reset, all interrupts, security-valid, overflow and violation outputs are 0, and both receive ports report empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_push | input | 1 | Trusted core pushes `t_wdata` toward the untrusted core |
| t_iso_push | input | 1 | Trusted core pushes `t_wdata` into the isolated FIFO and sets security-valid |
| t_wdata | input | DW | Trusted write data |
| t_send | input | 1 | Trusted core marks its outgoing message complete |
| t_done | input | 1 | Trusted core has finished reading its inbound message |
| t_ok_ack | input | 1 | Trusted core acknowledges its receive-complete interrupt |
| t_pop | input | 1 | Trusted core pops its inbound FIFO |
| t_rdata | output | DW | Head of the untrusted-to-trusted FIFO |
| t_rx_empty | output | 1 | Trusted inbound FIFO is empty |
| t_rdy_irq | output | 1 | Message-ready interrupt to the trusted core |
| t_ok_irq | output | 1 | Receive-complete interrupt to the trusted core |
| u_push | input | 1 | Untrusted core pushes `u_wdata` toward the trusted core |
| u_iso_push | input | 1 | Untrusted attempt to write the isolated FIFO (rejected) |
| u_sec_wr | input | 1 | Untrusted attempt to write the security flag (rejected) |
| u_wdata | input | DW | Untrusted write data |
| u_send | input | 1 | Untrusted core marks its outgoing message complete |
| u_done | input | 1 | Untrusted core has finished reading its inbound message |
| u_ok_ack | input | 1 | Untrusted core acknowledges its receive-complete interrupt |
| u_pop | input | 1 | Untrusted core pops the currently selected source |
| u_rdata | output | DW | Head of the isolated FIFO when security-valid is set, otherwise head of the shared inbound FIFO |
| u_rx_empty | output | 1 | The selected untrusted source is empty |
| u_rdy_irq | output | 1 | Message-ready interrupt to the untrusted core |
| u_ok_irq | output | 1 | Receive-complete interrupt to the untrusted core |
| u_key_irq | output | 1 | Security-valid flag, also the key interrupt to the untrusted core |
| t2u_ovf | output | 1 | Sticky overflow of the trusted-to-untrusted FIFO |
| u2t_ovf | output | 1 | Sticky overflow of the untrusted-to-trusted FIFO |
| iso_ovf | output | 1 | Sticky overflow of the isolated FIFO |
| violation | output | 1 | Sticky flag for a rejected untrusted write |

## Verification
A corrupted FIFO pointer or count shows up at the read port on the very next pop, either as a word out of sequence or as an empty flag that does not match the number of words pushed. A wrong security-valid state sends untrusted reads to the wrong FIFO. Key words then appear in place of shared data, or the reverse, and this is visible in the cycle after the isolated write or after the final isolated pop. Faults in the interrupt handshake show one cycle after a send, done or acknowledge strobe as an interrupt level that is wrong.

// File: rtl/mb_pkg.sv
// Shared definitions for the secure mailbox.
// Assumes: one clock domain; DEPTH is a power of two.
package mb_pkg;
    localparam int MB_DW    = 32;
    localparam int MB_DEPTH = 16;

    // Which FIFO feeds the untrusted read port
    typedef enum logic {
        SRC_SHARED   = 1'b0,
        SRC_ISOLATED = 1'b1
    } rd_src_e;
endpackage

// File: rtl/mb_fifo.sv
// Synchronous show-ahead word FIFO.
// The head word is on dout whenever empty is 0. A push while full is
// dropped and reported for one cycle on ovf_pulse. A pop while empty is
// ignored. Assumes DEPTH is a power of two.
module mb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic          ovf_pulse
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full      = (cnt == CW'(DEPTH));
    assign empty     = (cnt == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign dout      = mem[rd_ptr];
    assign count     = cnt;
    assign ovf_pulse = push && full;

    // Storage write: only accepted pushes land in memory
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // A full FIFO that is not popped keeps its occupancy (R2)
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    // An empty FIFO that is not pushed stays empty after a pop (R9)
    assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/mb_irq_pair.sv
// Interrupt handshake for one message direction.
// send raises rdy_irq to the receiver. done clears it and raises ok_irq
// to the sender, which holds until ack. send wins over done when both
// arrive in the same cycle.
module mb_irq_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic send,
    input  logic done,
    input  logic ack,
    output logic rdy_irq,
    output logic ok_irq
);
    // Message-ready level toward the receiver
    always_ff @(posedge clk) begin
        if (!rst_n)    rdy_irq <= 1'b0;
        else if (send) rdy_irq <= 1'b1;
        else if (done) rdy_irq <= 1'b0;
    end

    // Receive-complete level toward the sender
    always_ff @(posedge clk) begin
        if (!rst_n)    ok_irq <= 1'b0;
        else if (done) ok_irq <= 1'b1;
        else if (ack)  ok_irq <= 1'b0;
    end

    assert_send_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        send |=> rdy_irq);

    assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !send) |=> (!rdy_irq && ok_irq));

    assert_ok_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_irq) |-> $past(done));
endmodule

// File: rtl/sec_mailbox.sv
// Two-way mailbox between a trusted and an untrusted core, with a
// trusted-only isolated FIFO gated by a security-valid flag.
// Assumes both cores share clk. Strobes are single-cycle requests.
module sec_mailbox
    import mb_pkg::*;
#(
    parameter int DW    = MB_DW,
    parameter int DEPTH = MB_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          t_push,
    input  logic          t_iso_push,
    input  logic [DW-1:0] t_wdata,
    input  logic          t_send,
    input  logic          t_done,
    input  logic          t_ok_ack,
    input  logic          t_pop,
    output logic [DW-1:0] t_rdata,
    output logic          t_rx_empty,
    output logic          t_rdy_irq,
    output logic          t_ok_irq,
    input  logic          u_push,
    input  logic          u_iso_push,
    input  logic          u_sec_wr,
    input  logic [DW-1:0] u_wdata,
    input  logic          u_send,
    input  logic          u_done,
    input  logic          u_ok_ack,
    input  logic          u_pop,
    output logic [DW-1:0] u_rdata,
    output logic          u_rx_empty,
    output logic          u_rdy_irq,
    output logic          u_ok_irq,
    output logic          u_key_irq,
    output logic          t2u_ovf,
    output logic          u2t_ovf,
    output logic          iso_ovf,
    output logic          violation
);
    localparam int CW = $clog2(DEPTH+1);

    rd_src_e       src;
    logic          sec_valid;
    logic [DW-1:0] t2u_dout, iso_dout;
    logic          t2u_empty, iso_empty;
    logic          t2u_pop, iso_pop;
    logic [CW-1:0] iso_cnt;
    logic [2:0]    ovf_pulse;
    logic [2:0]    unused_full;
    logic [CW-1:0] unused_cnt_a, unused_cnt_b;
    logic          iso_last_pop;

    assign src          = sec_valid ? SRC_ISOLATED : SRC_SHARED;
    assign t2u_pop      = u_pop && (src == SRC_SHARED);
    assign iso_pop      = u_pop && (src == SRC_ISOLATED);
    assign iso_last_pop = iso_pop && (iso_cnt == CW'(1));

    // Trusted to untrusted shared queue
    mb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_t2u (
        .clk(clk), .rst_n(rst_n), .push(t_push), .din(t_wdata),
        .pop(t2u_pop), .dout(t2u_dout), .empty(t2u_empty),
        .full(unused_full[0]), .count(unused_cnt_a), .ovf_pulse(ovf_pulse[0]));

    // Untrusted to trusted shared queue
    mb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_u2t (
        .clk(clk), .rst_n(rst_n), .push(u_push), .din(u_wdata),
        .pop(t_pop), .dout(t_rdata), .empty(t_rx_empty),
        .full(unused_full[1]), .count(unused_cnt_b), .ovf_pulse(ovf_pulse[1]));

    // Isolated key queue, written only through the trusted port
    mb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_iso (
        .clk(clk), .rst_n(rst_n), .push(t_iso_push), .din(t_wdata),
        .pop(iso_pop), .dout(iso_dout), .empty(iso_empty),
        .full(unused_full[2]), .count(iso_cnt), .ovf_pulse(ovf_pulse[2]));

    // Untrusted read path selection
    assign u_rdata    = (src == SRC_ISOLATED) ? iso_dout  : t2u_dout;
    assign u_rx_empty = (src == SRC_ISOLATED) ? iso_empty : t2u_empty;
    assign u_key_irq  = sec_valid;

    // Handshakes, one per direction
    mb_irq_pair u_irq_t2u (
        .clk(clk), .rst_n(rst_n), .send(t_send), .done(u_done),
        .ack(t_ok_ack), .rdy_irq(u_rdy_irq), .ok_irq(t_ok_irq));

    mb_irq_pair u_irq_u2t (
        .clk(clk), .rst_n(rst_n), .send(u_send), .done(t_done),
        .ack(u_ok_ack), .rdy_irq(t_rdy_irq), .ok_irq(u_ok_irq));

    // Security-valid: set by trusted isolated writes, cleared on drain
    always_ff @(posedge clk) begin
        if (!rst_n)            sec_valid <= 1'b0;
        else if (t_iso_push)   sec_valid <= 1'b1;
        else if (iso_last_pop) sec_valid <= 1'b0;
    end

    // Sticky overflow and violation status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t2u_ovf   <= 1'b0;
            u2t_ovf   <= 1'b0;
            iso_ovf   <= 1'b0;
            violation <= 1'b0;
        end else begin
            if (ovf_pulse[0]) t2u_ovf <= 1'b1;
            if (ovf_pulse[1]) u2t_ovf <= 1'b1;
            if (ovf_pulse[2]) iso_ovf <= 1'b1;
            if (u_iso_push || u_sec_wr) violation <= 1'b1;
        end
    end

    assert_key_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        t_iso_push |=> (u_key_irq && !iso_empty));

    assert_key_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(u_key_irq) |-> $past(u_pop && !t_iso_push));

    assert_iso_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !t_iso_push |=> (iso_cnt <= $past(iso_cnt)));

    assert_violation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (u_iso_push || u_sec_wr) |=> violation);

    assert_key_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        u_key_irq |-> !u_rx_empty);
endmodule

// File: tb/sec_mailbox_tb.sv
module sec_mailbox_tb;
    localparam int DW = 32;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic t_push = 0, t_iso_push = 0, t_send = 0, t_done = 0, t_ok_ack = 0, t_pop = 0;
    logic u_push = 0, u_iso_push = 0, u_sec_wr = 0, u_send = 0, u_done = 0, u_ok_ack = 0, u_pop = 0;
    logic [DW-1:0] t_wdata = '0, u_wdata = '0;
    logic [DW-1:0] t_rdata, u_rdata;
    logic t_rx_empty, t_rdy_irq, t_ok_irq, u_rx_empty, u_rdy_irq, u_ok_irq, u_key_irq;
    logic t2u_ovf, u2t_ovf, iso_ovf, violation;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sec_mailbox #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .t_push(t_push), .t_iso_push(t_iso_push), .t_wdata(t_wdata), .t_send(t_send),
        .t_done(t_done), .t_ok_ack(t_ok_ack), .t_pop(t_pop), .t_rdata(t_rdata),
        .t_rx_empty(t_rx_empty), .t_rdy_irq(t_rdy_irq), .t_ok_irq(t_ok_irq),
        .u_push(u_push), .u_iso_push(u_iso_push), .u_sec_wr(u_sec_wr), .u_wdata(u_wdata),
        .u_send(u_send), .u_done(u_done), .u_ok_ack(u_ok_ack), .u_pop(u_pop),
        .u_rdata(u_rdata), .u_rx_empty(u_rx_empty), .u_rdy_irq(u_rdy_irq),
        .u_ok_irq(u_ok_irq), .u_key_irq(u_key_irq), .t2u_ovf(t2u_ovf),
        .u2t_ovf(u2t_ovf), .iso_ovf(iso_ovf), .violation(violation));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs are set 1 ns after an edge, checks follow
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clr();
        t_push = 0; t_iso_push = 0; t_send = 0; t_done = 0; t_ok_ack = 0; t_pop = 0;
        u_push = 0; u_iso_push = 0; u_sec_wr = 0; u_send = 0; u_done = 0; u_ok_ack = 0; u_pop = 0;
    endtask

    task automatic t_wr(input logic [DW-1:0] w);
        t_push = 1; t_wdata = w; tick(); clr();
    endtask

    task automatic u_wr(input logic [DW-1:0] w);
        u_push = 1; u_wdata = w; tick(); clr();
    endtask

    task automatic iso_wr(input logic [DW-1:0] w);
        t_iso_push = 1; t_wdata = w; tick(); clr();
    endtask

    task automatic u_rd(input string req, input logic [DW-1:0] exp);
        chk(req, {31'b0, u_rx_empty}, 32'd0);
        chk(req, u_rdata, exp);
        u_pop = 1; tick(); clr();
    endtask

    task automatic t_rd(input string req, input logic [DW-1:0] exp);
        chk(req, {31'b0, t_rx_empty}, 32'd0);
        chk(req, t_rdata, exp);
        t_pop = 1; tick(); clr();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R10 reset state
        chk("R10", {25'b0, t_rdy_irq, t_ok_irq, u_rdy_irq, u_ok_irq, u_key_irq, t2u_ovf, u2t_ovf}, 32'd0);
        chk("R10", {29'b0, iso_ovf, violation, 1'b0}, 32'd0);
        chk("R10", {30'b0, t_rx_empty, u_rx_empty}, 32'd3);

        // R1 message trusted to untrusted: type, length, payload; R3 send
        t_wr(32'h0000_0007); t_wr(32'h0000_0002); t_wr(32'hCAFE_0001); t_wr(32'hCAFE_0002);
        chk("R1", {31'b0, t_rx_empty}, 32'd1);
        t_send = 1; tick(); clr();
        chk("R3", {31'b0, u_rdy_irq}, 32'd1);
        tick();
        chk("R3", {31'b0, u_rdy_irq}, 32'd1);
        u_rd("R1", 32'h0000_0007); u_rd("R1", 32'h0000_0002);
        u_rd("R1", 32'hCAFE_0001); u_rd("R1", 32'hCAFE_0002);
        chk("R1", {31'b0, u_rx_empty}, 32'd1);
        // R4 done then ack
        u_done = 1; tick(); clr();
        chk("R4", {30'b0, u_rdy_irq, t_ok_irq}, 32'd1);
        tick();
        chk("R4", {31'b0, t_ok_irq}, 32'd1);
        t_ok_ack = 1; tick(); clr();
        chk("R4", {31'b0, t_ok_irq}, 32'd0);

        // R1 untrusted to trusted direction, independent queue
        for (int i = 0; i < 5; i++) u_wr(32'h5500_0000 + 32'(i * 3));
        chk("R1", {31'b0, u_rx_empty}, 32'd1);
        u_send = 1; tick(); clr();
        chk("R3", {31'b0, t_rdy_irq}, 32'd1);
        for (int i = 0; i < 5; i++) t_rd("R1", 32'h5500_0000 + 32'(i * 3));
        // R4 send and done together keep ready set
        u_send = 1; t_done = 1; tick(); clr();
        chk("R4", {30'b0, t_rdy_irq, u_ok_irq}, 32'd3);
        t_done = 1; tick(); clr();
        chk("R4", {31'b0, t_rdy_irq}, 32'd0);
        u_ok_ack = 1; tick(); clr();
        chk("R4", {31'b0, u_ok_irq}, 32'd0);

        // R2 fill sweep and overflow
        for (int i = 0; i < DEPTH; i++) t_wr(32'hA000_0000 + 32'(i * 257));
        chk("R2", {31'b0, t2u_ovf}, 32'd0);
        t_wr(32'hDEAD_DEAD);
        chk("R2", {31'b0, t2u_ovf}, 32'd1);
        chk("R2", {31'b0, u2t_ovf}, 32'd0);
        for (int i = 0; i < DEPTH; i++) u_rd("R2", 32'hA000_0000 + 32'(i * 257));
        chk("R2", {31'b0, u_rx_empty}, 32'd1);

        // R9 pop on empty ignored
        u_pop = 1; tick(); clr();
        chk("R9", {31'b0, u_rx_empty}, 32'd1);
        t_wr(32'h1234_5678); t_wr(32'h9ABC_DEF0);
        u_rd("R9", 32'h1234_5678); u_rd("R9", 32'h9ABC_DEF0);

        // R5 R6 R7 isolated key path
        t_wr(32'h5A5A_0001);
        iso_wr(32'hC0DE_0000); iso_wr(32'hC0DE_0001);
        chk("R5", {31'b0, u_key_irq}, 32'd1);
        u_rd("R6", 32'hC0DE_0000);
        chk("R7", {31'b0, u_key_irq}, 32'd1);
        u_rd("R6", 32'hC0DE_0001);
        chk("R7", {31'b0, u_key_irq}, 32'd0);
        u_rd("R7", 32'h5A5A_0001);
        chk("R7", {31'b0, u_rx_empty}, 32'd1);

        // R8 untrusted attempts rejected
        chk("R8", {31'b0, violation}, 32'd0);
        u_sec_wr = 1; tick(); clr();
        chk("R8", {30'b0, violation, u_key_irq}, 32'd2);
        u_iso_push = 1; u_wdata = 32'hBAD0_BAD0; tick(); clr();
        chk("R8", {31'b0, u_key_irq}, 32'd0);
        chk("R8", {31'b0, u_rx_empty}, 32'd1);
        iso_wr(32'hC0DE_0099);
        u_rd("R8", 32'hC0DE_0099);
        chk("R8", {31'b0, u_key_irq}, 32'd0);
        chk("R8", {31'b0, u_rx_empty}, 32'd1);
        chk("R2", {31'b0, iso_ovf}, 32'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule